// File: doc/BRIEF.md
# Three-Stage Clos Path Allocator

This block is the control-side route allocator for a symmetric three-stage Clos switch. The switch has `R_SW` input switches with `N_PER` ports each, `M_MID` middle switches and `R_SW` output switches, for a total of `N = N_PER*R_SW` ports. Input port `p` belongs to input switch `p / N_PER`. Output port `q` belongs to output switch `q / N_PER`. Every link between stages has one occupancy bit, where 0 means free and 1 means engaged. Each output port also has one occupancy bit.

A request table is presented together with a one-cycle `start` pulse. The table holds one valid bit and one destination output index per input port. The block then routes the requests one at a time, in ascending input order, without ever moving a connection it has already placed. For each request it probes the middle switches from index 0 upward, one per clock, and takes the first one that can carry the connection. If no middle switch can carry it, a sticky failure flag is raised and the remaining requests are still handled.

When `done` rises, three results are available at the outputs: the chosen middle switch for each input, a per-input routed bit, and a load count for each middle switch.

Top module: `clos_alloc`

## Requirements
- R1: After reset, `busy`, `done` and `failFlag` are 0, and `routeOk` and `midCount` are all zero.
- R2: A `start` pulse seen while not busy latches the request table and clears all link and port occupancy, all middle counters, `routeOk`, `routeMid` and `failFlag`. A later round is therefore unaffected by an earlier one.
- R3: Requests are handled in ascending input index. An earlier input gets the first choice of middle switches.
- R4: A middle switch `k` qualifies for input `p` with destination `q` only when all three of these are free: the link from input switch `p/N_PER` to `k`, the link from `k` to output switch `q/N_PER`, and output port `q`. The lowest-indexed qualifying `k` is chosen and reported in `routeMid[p*MW +: MW]`, with `routeOk[p]`=1.
- R5: A committed connection engages its three resources. No two routed connections share an input-to-middle link or a middle-to-output link.
- R6: When no middle switch qualifies, `routeOk[p]` stays 0, `failFlag` becomes 1 and stays 1 until the next `start`, and the later requests are still routed.
- R7: An entry whose valid bit is 0 is skipped in one clock, and its `routeOk` bit stays 0.
- R8: `busy` is high for the clock cycles after `start` as follows:
  - 1 cycle per invalid entry;
  - `k+1` cycles per entry routed through middle switch `k`;
  - `M_MID` cycles per failed entry;
  - 1 final cycle.

  Then `done` is high, with `busy` low, until the next `start`.
- R9: With `M_MID >= 2*N_PER-1`, every permutation of distinct destinations routes with `failFlag`=0.
- R10: `midCount[k*CW +: CW]` equals the number of connections routed through middle switch `k` in the current round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch request table and begin a round |
| reqValid | input | N | Valid bit per input port |
| reqDest | input | N*PW | Destination output index per input, entry p at [p*PW +: PW] |
| busy | output | 1 | Round in progress |
| done | output | 1 | Round finished, results valid |
| failFlag | output | 1 | At least one valid request could not be routed |
| routeOk | output | N | Input p was routed |
| routeMid | output | N*MW | Chosen middle switch per input |
| midCount | output | M_MID*CW | Connections carried per middle switch |

## Verification
The hardest situation to reach from the ports is a failure in the middle of a round, followed by correct routing of the entries after it. With `M_MID = 2*N_PER-1`, middle-switch exhaustion cannot occur for distinct destinations. The stimulus therefore reaches the failure by giving two inputs the same destination port, which makes the later one unroutable. A clean round is run immediately afterwards to show that the flag and all occupancy were cleared. Sharing of links is checked from the reported middle indices alone, by pairing routed entries that share an input switch or an output switch.

// File: rtl/clos_alloc_pkg.sv
package clos_alloc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} allocState_t;

  typedef struct packed {
    logic load;
    logic commit;
    logic failMark;
  } allocStrobe_t;
endpackage

// File: rtl/clos_alloc_ctrl.sv
module clos_alloc_ctrl
  import clos_alloc_pkg::*;
#(
  parameter int NPORT = 6,
  parameter int M_MID = 3,
  parameter int IW = $clog2(NPORT + 1),
  parameter int MW = (M_MID > 1) ? $clog2(M_MID) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          curValid,
  input  logic          qualify,
  output allocStrobe_t  stb,
  output logic [IW-1:0] reqIdx,
  output logic [MW-1:0] mid,
  output logic          busy,
  output logic          done
);
  allocState_t state;
  logic atEnd, lastMid;

  assign atEnd   = (reqIdx == IW'(NPORT));
  assign lastMid = (mid == MW'(M_MID - 1));

  always_comb begin
    stb          = '0;
    stb.load     = start && (state != ST_SCAN);
    stb.commit   = (state == ST_SCAN) && !atEnd && curValid && qualify;
    stb.failMark = (state == ST_SCAN) && !atEnd && curValid && !qualify && lastMid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      reqIdx <= '0;
      mid    <= '0;
    end else begin
      case (state)
        ST_SCAN: begin
          if (atEnd) begin
            state <= ST_DONE;
          end else if (!curValid || qualify || lastMid) begin
            reqIdx <= reqIdx + IW'(1);
            mid    <= '0;
          end else begin
            mid <= mid + MW'(1);
          end
        end
        default: begin
          if (start) begin
            state  <= ST_SCAN;
            reqIdx <= '0;
            mid    <= '0;
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_SCAN);
  assign done = (state == ST_DONE);

  // R8: busy and done never overlap
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4: the probe index stays within the middle stage
  a_r4_mid_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mid < MW'(M_MID));

  // R8: a round, once finished, holds done until a new start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/clos_alloc_dp.sv
module clos_alloc_dp
  import clos_alloc_pkg::*;
#(
  parameter int N_PER = 2,
  parameter int R_SW = 3,
  parameter int M_MID = 3,
  parameter int NPORT = N_PER * R_SW,
  parameter int IW = $clog2(NPORT + 1),
  parameter int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
  parameter int MW = (M_MID > 1) ? $clog2(M_MID) : 1,
  parameter int SW = (R_SW > 1) ? $clog2(R_SW) : 1,
  parameter int CW = $clog2(R_SW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  allocStrobe_t          stb,
  input  logic [IW-1:0]         reqIdx,
  input  logic [MW-1:0]         mid,
  input  logic [NPORT-1:0]      reqValid,
  input  logic [NPORT*PW-1:0]   reqDest,
  output logic                  curValid,
  output logic                  qualify,
  output logic                  failFlag,
  output logic [NPORT-1:0]      routeOk,
  output logic [NPORT*MW-1:0]   routeMid,
  output logic [M_MID*CW-1:0]   midCount
);
  logic [NPORT-1:0] validQ;
  logic [PW-1:0]    destQ    [NPORT];
  logic [M_MID-1:0] inLink   [R_SW];
  logic [R_SW-1:0]  midLink  [M_MID];
  logic [NPORT-1:0] outPort;
  logic [CW-1:0]    cnt      [M_MID];
  logic [MW-1:0]    midSel   [NPORT];

  logic [PW-1:0] curPort, curDest;
  logic [SW-1:0] curSw, dstSw;
  logic          inRange;

  assign inRange  = reqIdx < IW'(NPORT);
  assign curPort  = inRange ? PW'(reqIdx) : '0;
  assign curDest  = destQ[curPort];
  assign curSw    = SW'(curPort / PW'(N_PER));
  assign dstSw    = SW'(curDest / PW'(N_PER));
  assign curValid = inRange && validQ[curPort];
  assign qualify  = curValid && !inLink[curSw][mid] && !midLink[mid][dstSw]
                    && !outPort[curDest];

  always_ff @(posedge clk) begin
    if (!rst_n || stb.load) begin
      failFlag <= 1'b0;
      outPort  <= '0;
      routeOk  <= '0;
      validQ   <= rst_n ? reqValid : '0;
      for (int s = 0; s < R_SW; s++) inLink[s] <= '0;
      for (int k = 0; k < M_MID; k++) begin
        midLink[k] <= '0;
        cnt[k]     <= '0;
      end
      for (int p = 0; p < NPORT; p++) begin
        destQ[p]  <= rst_n ? reqDest[p*PW +: PW] : '0;
        midSel[p] <= '0;
      end
    end else begin
      if (stb.commit) begin
        inLink[curSw][mid]   <= 1'b1;
        midLink[mid][dstSw]  <= 1'b1;
        outPort[curDest]     <= 1'b1;
        cnt[mid]             <= cnt[mid] + CW'(1);
        midSel[curPort]      <= mid;
        routeOk[curPort]     <= 1'b1;
      end
      if (stb.failMark) failFlag <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_route
      assign routeMid[g*MW +: MW] = midSel[g];
    end
    for (g = 0; g < M_MID; g++) begin : g_count
      assign midCount[g*CW +: CW] = cnt[g];
    end
  endgenerate

  // checker views of the occupancy state
  logic [R_SW*M_MID-1:0] inFlat;
  logic [M_MID*R_SW-1:0] midFlat;
  int countSum;
  always_comb begin
    countSum = 0;
    for (int s = 0; s < R_SW; s++) inFlat[s*M_MID +: M_MID] = inLink[s];
    for (int k = 0; k < M_MID; k++) begin
      midFlat[k*R_SW +: R_SW] = midLink[k];
      countSum += int'(cnt[k]);
    end
  end

  // R5: engaged links are never released within a round
  a_r5_links_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.load |=> (($past(inFlat) & ~inFlat) == '0));

  // R10: counters agree with engaged input-side links
  a_r10_count_in: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inFlat) == countSum);

  // R5: each connection engages exactly one distinct middle-to-output link
  a_r5_mid_links: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(midFlat) == countSum);

  // R5: each connection engages exactly one distinct output port
  a_r5_out_ports: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(outPort) == countSum);

  // R6: failure flag holds until the next round
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (failFlag && !stb.load) |=> failFlag);
endmodule

// File: rtl/clos_alloc.sv
module clos_alloc
  import clos_alloc_pkg::*;
#(
  parameter int N_PER = 2,
  parameter int R_SW = 3,
  parameter int M_MID = 3,
  localparam int NPORT = N_PER * R_SW,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int MW = (M_MID > 1) ? $clog2(M_MID) : 1,
  localparam int CW = $clog2(R_SW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NPORT-1:0]    reqValid,
  input  logic [NPORT*PW-1:0] reqDest,
  output logic                busy,
  output logic                done,
  output logic                failFlag,
  output logic [NPORT-1:0]    routeOk,
  output logic [NPORT*MW-1:0] routeMid,
  output logic [M_MID*CW-1:0] midCount
);
  localparam int IW = $clog2(NPORT + 1);

  allocStrobe_t  stb;
  logic [IW-1:0] reqIdx;
  logic [MW-1:0] mid;
  logic          curValid, qualify;

  clos_alloc_ctrl #(.NPORT(NPORT), .M_MID(M_MID), .IW(IW), .MW(MW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .curValid(curValid),
    .qualify(qualify), .stb(stb), .reqIdx(reqIdx), .mid(mid),
    .busy(busy), .done(done)
  );

  clos_alloc_dp #(.N_PER(N_PER), .R_SW(R_SW), .M_MID(M_MID)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqIdx(reqIdx), .mid(mid),
    .reqValid(reqValid), .reqDest(reqDest), .curValid(curValid),
    .qualify(qualify), .failFlag(failFlag), .routeOk(routeOk),
    .routeMid(routeMid), .midCount(midCount)
  );
endmodule

// File: tb/clos_alloc_test.sv
module clos_alloc_test;
  localparam int CLK_P = 10;
  localparam int NP = 2, RS = 3, MM = 3;
  localparam int N = NP * RS;
  localparam int PW = $clog2(N);
  localparam int MW = $clog2(MM);
  localparam int CW = $clog2(RS + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [N-1:0] reqValid = '0;
  logic [N*PW-1:0] reqDest = '0;
  logic busy, done, failFlag;
  logic [N-1:0] routeOk;
  logic [N*MW-1:0] routeMid;
  logic [MM*CW-1:0] midCount;

  clos_alloc #(.N_PER(NP), .R_SW(RS), .M_MID(MM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .reqValid(reqValid),
    .reqDest(reqDest), .busy(busy), .done(done), .failFlag(failFlag),
    .routeOk(routeOk), .routeMid(routeMid), .midCount(midCount)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int tDest[N];
  bit tValid[N];
  int expMid[N];
  bit expOk[N];
  bit expFail;
  int expCnt[MM];
  int expLen;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: ordered greedy placement with occupancy sets
  task automatic model();
    bit inUse[RS][MM];
    bit midUse[MM][RS];
    bit portUse[N];
    for (int s = 0; s < RS; s++)
      for (int k = 0; k < MM; k++) begin inUse[s][k] = 0; midUse[k][s] = 0; end
    for (int p = 0; p < N; p++) portUse[p] = 0;
    for (int k = 0; k < MM; k++) expCnt[k] = 0;
    expFail = 0;
    expLen = 1;
    for (int p = 0; p < N; p++) begin
      expOk[p] = 0; expMid[p] = 0;
      if (!tValid[p]) begin expLen += 1; continue; end
      begin
        int found = -1;
        for (int k = 0; k < MM && found < 0; k++)
          if (!inUse[p/NP][k] && !midUse[k][tDest[p]/NP] && !portUse[tDest[p]]) found = k;
        if (found < 0) begin
          expFail = 1; expLen += MM;
        end else begin
          inUse[p/NP][found] = 1; midUse[found][tDest[p]/NP] = 1;
          portUse[tDest[p]] = 1; expCnt[found]++;
          expOk[p] = 1; expMid[p] = found; expLen += found + 1;
        end
      end
    end
  endtask

  task automatic runRound(input bool_perm);
    model();
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      reqValid[p] = tValid[p];
      reqDest[p*PW +: PW] = PW'(tDest[p]);
    end
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 1; k <= expLen; k++) begin
      chk(busy == 1 && done == 0, "R8 busy window", {busy, done}, 2);
      @(negedge clk);
    end
    chk(done == 1 && busy == 0, "R8 done after window", {busy, done}, 1);
    chk(failFlag == expFail, "R6 failFlag", failFlag, expFail);
    if (bool_perm) chk(failFlag == 0, "R9 permutation routes", failFlag, 0);
    for (int p = 0; p < N; p++) begin
      chk(routeOk[p] == expOk[p], "R7/R6 routeOk", routeOk[p], expOk[p]);
      if (expOk[p])
        chk(int'(routeMid[p*MW +: MW]) == expMid[p], "R3/R4 routeMid",
            int'(routeMid[p*MW +: MW]), expMid[p]);
    end
    for (int k = 0; k < MM; k++)
      chk(int'(midCount[k*CW +: CW]) == expCnt[k], "R10 midCount",
          int'(midCount[k*CW +: CW]), expCnt[k]);
    // R5: link sharing judged from reported results only
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (routeOk[a] && routeOk[b] && routeMid[a*MW +: MW] == routeMid[b*MW +: MW]) begin
          chk(a/NP != b/NP, "R5 input link shared", a, b);
          chk(tDest[a]/NP != tDest[b]/NP, "R5 output link shared", a, b);
        end
    repeat (3) @(negedge clk);
    chk(done == 1 && busy == 0, "R8 done holds", {busy, done}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && failFlag == 0, "R1 reset flags", {busy, done, failFlag}, 0);
    chk(routeOk == 0 && midCount == 0, "R1 reset results", int'(routeOk), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle after reset", {busy, done}, 0);

    // R4/R9 identity permutation
    for (int p = 0; p < N; p++) begin tValid[p] = 1; tDest[p] = p; end
    runRound(1);
    // R3 reversed permutation
    for (int p = 0; p < N; p++) tDest[p] = N - 1 - p;
    runRound(1);
    // R9 rotations and a strided pattern
    for (int r = 1; r < N; r++) begin
      for (int p = 0; p < N; p++) tDest[p] = (p + r) % N;
      runRound(1);
    end
    for (int p = 0; p < N; p++) tDest[p] = (p * 5 + 1) % N;
    runRound(1);
    // R6 duplicate destination: input 3 collides with input 0, later ones still route
    tDest[0] = 4; tDest[1] = 0; tDest[2] = 2; tDest[3] = 4; tDest[4] = 1; tDest[5] = 3;
    runRound(0);
    chk(failFlag == 1 && routeOk[3] == 0 && routeOk[5] == 1, "R6 fail and continue",
        int'(routeOk), 6'b110111);
    // R2 clean round straight after a failure
    for (int p = 0; p < N; p++) tDest[p] = p;
    runRound(1);
    chk(failFlag == 0, "R2 flag cleared by start", failFlag, 0);
    // R7 partial request table
    for (int p = 0; p < N; p++) begin tValid[p] = (p % 2 == 0); tDest[p] = (p + 3) % N; end
    runRound(0);
    // R7 empty table
    for (int p = 0; p < N; p++) tValid[p] = 0;
    runRound(0);
    chk(routeOk == 0, "R7 empty table routes nothing", int'(routeOk), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule